// File: doc/BRIEF.md
# Interrupt Request Latch and Enable Port

This block gathers interrupt requests from a small set of sources, such as a video line-interrupt signal and periodic timers. It turns them into one interrupt request for the CPU. Each source line is watched for a low-to-high transition. A transition sets that source's pending flag. The flag stays set until software clears it, whether or not the source is enabled. The CPU interrupt request is active while any source has both its pending flag and its enable set.

Software reaches the block through one byte-wide I/O port. Each source owns a pair of adjacent bits in that byte: the even bit is its enable and the odd bit above it is its pending flag. One write loads every enable and also acknowledges pending flags, by clearing each flag whose bit is written as 1. A read of the port returns the enables and pending flags merged into one byte. This lets an interrupt handler find out which sources fired.

Top module: `irq_latch_unit`

## Requirements
- R1: Reset clears all enables and all pending flags, so a port read returns 0x00 and `irqOut` is low.
- R2: A write (`ioWr` high with `ioAddr` equal to 0xB4) loads the enables from the written byte ANDed with 0x55. Source k's enable is bit 2k.
- R3: On that write, every source k whose bit 2k+1 is written as 1 has its pending flag cleared. A flag whose bit is written as 0 keeps its value.
- R4: A read (`ioRd` high with `ioAddr` equal to 0xB4) returns on `ioRdData`, in the same cycle, a byte with source k's enable in bit 2k and its pending flag in bit 2k+1.
- R5: `irqOut` is high exactly when at least one source has both its pending flag and its enable set. It follows register changes on the clock edge that makes them.
- R6: A pending flag is set only by a rising edge of its source line, sampled on two consecutive clocks. A line held high after its flag is cleared does not set the flag again.
- R7: A rising edge sets the pending flag even while the source is disabled. The flag is then readable, and `irqOut` stays low.
- R8: When a rising edge and a clearing write hit the same source in the same cycle, the flag ends up set.
- R9: Writes to any other address change nothing. A read at any other address, or with `ioRd` low, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcLine | input | 4 | Raw interrupt source lines, one per source |
| ioAddr | input | 8 | I/O port address |
| ioWrData | input | 8 | I/O write data |
| ioWr | input | 1 | I/O write strobe, one cycle per write |
| ioRd | input | 1 | I/O read strobe |
| ioRdData | output | 8 | I/O read data, valid while `ioRd` is high |
| irqOut | output | 1 | Interrupt request to the CPU, active high |

## Verification
The assertions assume that the source lines are synchronous to `clk`. They also assume that each source line is stable between clock edges, so that every level is sampled once per cycle. The bench changes source lines and I/O strobes only on the falling edge. Each write strobe is held for a single cycle, so one write is one register update. The bench keeps a source line held high across a clearing write, and raises another line in the same cycle as a clear. Both cases happen in cycles chosen so that the edge detector's previous sample is known.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  // Strobes decoded from the I/O bus for the register datapath
  typedef struct packed {
    logic wrHit;
    logic rdHit;
  } portStrobeT;
endpackage

// File: rtl/irq_port_ctrl.sv
module irq_port_ctrl
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hB4
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  output portStrobeT        strobe
);
  logic addrMatch;

  assign addrMatch    = (ioAddr == PORT_ADDR);
  assign strobe.wrHit = ioWr && addrMatch;
  assign strobe.rdHit = ioRd && addrMatch;
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_unit_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int DATA_W = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  portStrobeT         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcLine,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] riseDet;
  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] pendingQ;
  logic [NUM_SRC-1:0] enWrite;
  logic [NUM_SRC-1:0] clrWrite;
  logic [DATA_W-1:0]  statusByte;

  // Split the interleaved byte into per-source enable and clear fields
  genvar k;
  generate
    for (k = 0; k < NUM_SRC; k++) begin : g_src
      assign enWrite[k]        = wrData[2*k];
      assign clrWrite[k]       = wrData[2*k+1];
      assign statusByte[2*k]   = enableQ[k];
      assign statusByte[2*k+1] = pendingQ[k];
      assign riseDet[k]        = srcLine[k] && !prevQ[k];

      always_ff @(posedge clk) begin
        if (rst) begin
          pendingQ[k] <= 1'b0;
        end else if (riseDet[k]) begin
          pendingQ[k] <= 1'b1;
        end else if (strobe.wrHit && clrWrite[k]) begin
          pendingQ[k] <= 1'b0;
        end
      end

      // A clearing write with no edge leaves the flag low
      p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe.wrHit && wrData[2*k+1] && !riseDet[k]) |=> !pendingQ[k]);

      // Without an edge a low flag stays low
      p_no_spurious_set_r6: assert property (@(posedge clk) disable iff (rst)
        (!pendingQ[k] && !(srcLine[k] && !prevQ[k])) |=> !pendingQ[k]);

      // An edge always leaves the flag set, even with a clear
      p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        riseDet[k] |=> pendingQ[k]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ   <= '0;
      enableQ <= '0;
    end else begin
      prevQ <= srcLine;
      if (strobe.wrHit) begin
        enableQ <= enWrite;
      end
    end
  end

  assign rdData = strobe.rdHit ? statusByte : '0;
  assign irqOut = |(enableQ & pendingQ);

  p_enable_load_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.wrHit |=> (rdDataView() == ($past(wrData) & evenMask())));

  p_enable_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrHit |=> $stable(enableQ));

  function automatic logic [DATA_W-1:0] evenMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[2*i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] rdDataView();
    return statusByte & evenMask();
  endfunction
endmodule

// File: rtl/irq_latch_unit.sv
module irq_latch_unit
  import irq_unit_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hB4,
  localparam int DATA_W = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcLine,
  input  logic [ADDR_W-1:0]  ioAddr,
  input  logic [DATA_W-1:0]  ioWrData,
  input  logic               ioWr,
  input  logic               ioRd,
  output logic [DATA_W-1:0]  ioRdData,
  output logic               irqOut
);
  portStrobeT strobe;

  irq_port_ctrl #(
    .ADDR_W   (ADDR_W),
    .PORT_ADDR(PORT_ADDR)
  ) u_ctrl (
    .ioAddr(ioAddr),
    .ioWr  (ioWr),
    .ioRd  (ioRd),
    .strobe(strobe)
  );

  irq_datapath #(
    .NUM_SRC(NUM_SRC)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrData (ioWrData),
    .srcLine(srcLine),
    .rdData (ioRdData),
    .irqOut (irqOut)
  );

  // Port read data is quiet unless the port is addressed for reading
  p_read_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !(ioRd && ioAddr == PORT_ADDR) |-> (ioRdData == '0));
endmodule

// File: tb/irq_latch_unit_test.sv
module irq_latch_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PORT = 8'hB4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] srcLine = '0;
  logic [7:0] ioAddr = '0;
  logic [7:0] ioWrData = '0;
  logic       ioWr = 1'b0;
  logic       ioRd = 1'b0;
  logic [7:0] ioRdData;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_latch_unit uut (
    .clk(clk), .rst(rst), .srcLine(srcLine), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioWr(ioWr), .ioRd(ioRd),
    .ioRdData(ioRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic portWrite(input logic [7:0] addr, input logic [7:0] data);
    ioAddr = addr; ioWrData = data; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic portRead(input logic [7:0] addr, output logic [7:0] val);
    ioAddr = addr; ioRd = 1'b1;
    #1 val = ioRdData;
    ioRd = 1'b0;
  endtask

  task automatic raise(input int idx);
    srcLine[idx] = 1'b1;
    @(negedge clk);
  endtask

  task automatic lower(input int idx);
    srcLine[idx] = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    portRead(PORT, v);
    check("R1 reset read", v, 8'h00);
    check("R1 reset irq", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testEnableLoad();
    logic [7:0] v;
    portWrite(PORT, 8'hFF);
    portRead(PORT, v);
    check("R2 enables masked to even bits", v, 8'h55);
    check("R5 no pending so irq low", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testMaskedPending();
    logic [7:0] v;
    portWrite(PORT, 8'h00);
    raise(1);
    portRead(PORT, v);
    check("R7 masked flag readable", v, 8'h08);
    check("R7 masked irq low", {7'b0, irqOut}, 8'h00);
    // line still high: clear and check it does not re-latch
    portWrite(PORT, 8'hFF);
    @(negedge clk); @(negedge clk);
    portRead(PORT, v);
    check("R6 held level does not re-set", v, 8'h55);
    lower(1);
  endtask

  task automatic testIrqOutput();
    logic [7:0] v;
    raise(1);
    check("R5 irq on enabled pending", {7'b0, irqOut}, 8'h01);
    portRead(PORT, v);
    check("R4 status merge", v, 8'h5D);
    portWrite(PORT, 8'h04);
    check("R3 zero clear bit keeps flag", {7'b0, irqOut}, 8'h01);
    portWrite(PORT, 8'h01);
    check("R5 irq low when its enable drops", {7'b0, irqOut}, 8'h00);
    portRead(PORT, v);
    check("R4 status after enable change", v, 8'h09);
    portWrite(PORT, 8'h08);
    portRead(PORT, v);
    check("R3 clear of flag", v, 8'h00);
    lower(1);
  endtask

  task automatic testSelectiveClear();
    logic [7:0] v;
    raise(0);
    raise(2);
    portRead(PORT, v);
    check("R6 two edges latched", v, 8'h22);
    portWrite(PORT, 8'h20);
    portRead(PORT, v);
    check("R3 only written flag cleared", v, 8'h02);
  endtask

  task automatic testSetWins();
    logic [7:0] v;
    srcLine[3] = 1'b1;
    portWrite(PORT, 8'h80);
    portRead(PORT, v);
    check("R8 edge beats clear", v, 8'h82);
  endtask

  task automatic testOtherAddress();
    logic [7:0] v;
    portWrite(8'hB5, 8'hFF);
    portRead(PORT, v);
    check("R9 foreign write ignored", v, 8'h82);
    portRead(8'hB5, v);
    check("R9 foreign read zero", v, 8'h00);
    ioAddr = PORT;
    #1 check("R9 no read strobe zero", ioRdData, 8'h00);
  endtask

  task automatic testResetAgain();
    logic [7:0] v;
    portWrite(PORT, 8'h55);
    raise(2);
    check("R5 irq before reset", {7'b0, irqOut}, 8'h01);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    portRead(PORT, v);
    check("R1 reset clears registers", v, 8'h00);
    check("R1 reset drops irq", {7'b0, irqOut}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testEnableLoad();
    testMaskedPending();
    testIrqOutput();
    testSelectiveClear();
    testSetWins();
    testOtherAddress();
    testResetAgain();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule